// File: doc/BRIEF.md
# Programmable Down-Counter Channel

This block is one channel of a programmable interval timer. It holds a 16-bit initial value and a 16-bit down-counter that moves only on cycles where the `tick` count enable is high. A `load` strobe writes a new initial value and an operating mode in the same cycle, and counting restarts at once. The `out` line follows the waveform of the chosen mode, and `irq` presents `out` to an interrupt controller. The `irq_mask` input holds `irq` low while it is high.

There are six modes. Mode 0 is interrupt on terminal count, and mode 1 is a one-shot that the gate can retrigger. Mode 2 is a rate generator and mode 3 a square wave. Mode 4 is a strobe started by software, and mode 5 a strobe that the gate can restart. Mode codes 6 and 7 act as 2 and 3. A load value of zero stands for 65536 counts.

The control is a three-state machine:
- `ST_IDLE` is the reset state. Nothing has been loaded and ticks are ignored.
- `ST_COUNT` is the first pass after a load or a gate restart.
- `ST_EXPIRED` is entered in modes 0, 1, 4 and 5 once the count reaches zero.

Transitions:
- `load` moves any state to `ST_COUNT`.
- A gate restart moves `ST_COUNT` or `ST_EXPIRED` back to `ST_COUNT`.
- The terminal tick moves `ST_COUNT` to `ST_EXPIRED` in the one-shot modes.
- Modes 2 and 3 stay in `ST_COUNT` and reload on their own.

Top module: `pit_channel_core`

## Requirements
- R1: After reset `count` is 0, `out` is 1 and `irq` is 1. Ticks before the first load change neither `count` nor `out`.
- R2: One cycle after `load`, `count` equals `load_val`, and the mode is taken from `mode_sel` in that cycle only. Later changes of `mode_sel` have no effect until the next load. Codes 6 and 7 behave as 2 and 3. A value of 0 gives 65536 ticks.
- R3: Mode 0: `out` is 0 after load and goes to 1 on the tick that brings the count to 0, after N ticks. It stays 1. The count keeps decrementing and wraps from 0 to 65535.
- R4: Mode 1: `out` is 0 after load or after a gate rising edge, and goes to 1 after N ticks. A gate rising edge reloads the initial value. The gate level does not stop counting.
- R5: Mode 2: the count runs N down to 1 and then reloads N, giving a period of N ticks. `out` is 0 exactly while the count is 1.
- R6: Mode 3, for N of 2 or more: the count falls by 2 per tick. `out` is 1 for ceil(N/2) ticks from a count of N. It is then 0 for floor(N/2) ticks from a count of N rounded down to even. The cycle then repeats.
- R7: Mode 4: `out` is 1, except for a single one-tick low pulse when the count first reaches 0 after the load. The count then keeps wrapping.
- R8: Mode 5: same as mode 4, but the gate level does not stop counting, and a gate rising edge reloads the initial value with `out` high.
- R9: In modes 0, 2, 3 and 4 a tick with the gate low leaves `count` unchanged.
- R10: In modes 2 and 3 a gate rising edge reloads the initial value and sets `out` to 1.
- R11: `irq` equals `out` while `irq_mask` is 0 and is 0 while `irq_mask` is 1. Releasing the mask restores `irq` from the current `out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable, one count step per high cycle |
| gate | input | 1 | Gate: level enables counting or rising edge restarts, by mode |
| mode_sel | input | 3 | Mode captured on load (0 to 5; 6 and 7 alias 2 and 3) |
| load | input | 1 | Load strobe, highest priority |
| load_val | input | 16 (CNT_W) | Initial value written by load, 0 meaning 65536 |
| irq_mask | input | 1 | Holds irq low while high |
| count | output | 16 (CNT_W) | Current counter value |
| out | output | 1 | Mode waveform output |
| irq | output | 1 | Interrupt request, out gated by the mask |

## Verification
The bound checker watches every cycle for the following:
- loaded values appear in the counter;
- the step of two in square-wave mode;
- a frozen count under a low gate;
- the rate generator's low output being tied to a count of one;
- mode 0 raising its output only at zero;
- the restart behaviour on gate edges;
- the interrupt mask.

Whole waveforms need the bench's sweeps over modes and small initial values, where period lengths, half-period asymmetry for odd counts, single-pulse strobes and the 65536-tick load of zero are compared against arithmetic expectations. The bench scenarios also cover mode capture at load, aliasing of codes 6 and 7, and gate independence of modes 1 and 5.

// File: rtl/pit_chan_pkg.sv
package pit_chan_pkg;

    typedef enum logic [2:0] {
        MD_TERM     = 3'd0,
        MD_ONESHOT  = 3'd1,
        MD_RATE     = 3'd2,
        MD_SQUARE   = 3'd3,
        MD_SWSTROBE = 3'd4,
        MD_HWSTROBE = 3'd5
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COUNT   = 2'd1,
        ST_EXPIRED = 2'd2
    } state_e;

    // codes 6 and 7 fold onto the periodic modes
    function automatic mode_e fold_mode(input logic [2:0] m);
        return (m[2] && m[1]) ? mode_e'({1'b0, m[1:0]}) : mode_e'(m);
    endfunction

    // modes whose counting stops while the gate is low
    function automatic logic gate_level_mode(input mode_e m);
        return (m == MD_TERM) || (m == MD_RATE) || (m == MD_SQUARE) || (m == MD_SWSTROBE);
    endfunction

    // modes restarted by a gate rising edge
    function automatic logic gate_edge_mode(input mode_e m);
        return (m == MD_ONESHOT) || (m == MD_RATE) || (m == MD_SQUARE) || (m == MD_HWSTROBE);
    endfunction

endpackage

// File: rtl/pit_gate_edge.sv
module pit_gate_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic gate,
    output logic rise
);
    logic gate_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= gate;
    end

    assign rise = gate && !gate_q;
endmodule

// File: rtl/pit_count_path.sv
module pit_count_path
    import pit_chan_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             restart,
    input  logic             step,
    input  mode_e            mode_q,
    input  logic             out_q,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] init_val,
    output logic             period_end
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

    logic [CNT_W-1:0] dec_amt;

    always_comb begin
        unique case (mode_q)
            MD_RATE:   period_end = (count == ONE);
            MD_SQUARE: period_end = (count == ONE) || (count == TWO);
            default:   period_end = 1'b0;
        endcase
        dec_amt = (mode_q == MD_SQUARE) ? TWO : ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count    <= '0;
            init_val <= '0;
        end else if (load) begin
            init_val <= load_val;
            count    <= load_val;
        end else if (restart) begin
            count <= init_val;
        end else if (step) begin
            if (period_end) begin
                // square wave: low half restarts from the value rounded down to even
                count <= (mode_q == MD_SQUARE && out_q) ? (init_val & ~ONE) : init_val;
            end else begin
                count <= count - dec_amt;
            end
        end
    end
endmodule

// File: rtl/pit_ctrl_fsm.sv
module pit_ctrl_fsm
    import pit_chan_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [2:0]       mode_sel,
    input  logic             tick,
    input  logic             gate,
    input  logic             rise,
    input  logic [CNT_W-1:0] count,
    input  logic             period_end,
    output state_e           state,
    output mode_e            mode_q,
    output logic             out,
    output logic             step,
    output logic             restart
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

    state_e state_nx;
    mode_e  mode_nx;
    logic   running;
    logic   term_hit;
    mode_e  load_mode;

    always_comb begin
        load_mode = fold_mode(mode_sel);
        running   = (state != ST_IDLE);
        restart   = rise && running && gate_edge_mode(mode_q) && !load;
        step      = tick && running && !load && !restart &&
                    (gate || !gate_level_mode(mode_q));
        term_hit  = step && (state == ST_COUNT) && (count == ONE) &&
                    (mode_q == MD_TERM || mode_q == MD_ONESHOT ||
                     mode_q == MD_SWSTROBE || mode_q == MD_HWSTROBE);

        state_nx = state;
        mode_nx  = mode_q;
        if (load) begin
            state_nx = ST_COUNT;
            mode_nx  = load_mode;
        end else if (restart) begin
            state_nx = ST_COUNT;
        end else if (term_hit) begin
            state_nx = ST_EXPIRED;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            mode_q <= MD_TERM;
        end else begin
            state  <= state_nx;
            mode_q <= mode_nx;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out <= 1'b1;
        end else if (load) begin
            out <= !(load_mode == MD_TERM || load_mode == MD_ONESHOT);
        end else if (restart) begin
            out <= (mode_q != MD_ONESHOT);
        end else begin
            unique case (mode_q)
                MD_TERM, MD_ONESHOT: begin
                    if (term_hit) out <= 1'b1;
                end
                MD_RATE: begin
                    if (step) out <= (count != TWO);
                end
                MD_SQUARE: begin
                    if (step && period_end) out <= !out;
                end
                MD_SWSTROBE, MD_HWSTROBE: begin
                    if (tick && running) out <= !term_hit;
                end
                default: out <= out;
            endcase
        end
    end
endmodule

// File: rtl/pit_channel_core.sv
module pit_channel_core
    import pit_chan_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             gate,
    input  logic [2:0]       mode_sel,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             irq_mask,
    output logic [CNT_W-1:0] count,
    output logic             out,
    output logic             irq
);
    logic             rise;
    logic             step;
    logic             restart;
    logic             period_end;
    logic [CNT_W-1:0] init_val;
    state_e           state;
    mode_e            mode_q;

    pit_gate_edge u_gate (
        .clk   (clk),
        .rst_n (rst_n),
        .gate  (gate),
        .rise  (rise)
    );

    pit_ctrl_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .mode_sel   (mode_sel),
        .tick       (tick),
        .gate       (gate),
        .rise       (rise),
        .count      (count),
        .period_end (period_end),
        .state      (state),
        .mode_q     (mode_q),
        .out        (out),
        .step       (step),
        .restart    (restart)
    );

    pit_count_path #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .load_val   (load_val),
        .restart    (restart),
        .step       (step),
        .mode_q     (mode_q),
        .out_q      (out),
        .count      (count),
        .init_val   (init_val),
        .period_end (period_end)
    );

    assign irq = out && !irq_mask;
endmodule

// File: rtl/pit_chan_checker.sv
module pit_chan_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             gate,
    input logic             load,
    input logic [CNT_W-1:0] load_val,
    input logic             irq_mask,
    input logic [CNT_W-1:0] count,
    input logic             out,
    input logic             irq,
    input logic [1:0]       state,
    input logic [2:0]       mode_q,
    input logic             step,
    input logic             rise,
    input logic [CNT_W-1:0] init_val,
    input logic             period_end
);
    logic active;
    assign active = (state != 2'd0);

    assert_load_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> count == $past(load_val));

    assert_term_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 3'd0 && $rose(out) && !$past(load)) |-> count == '0);

    assert_oneshot_retrig_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && active && !load && (mode_q == 3'd1 || mode_q == 3'd5))
        |=> count == $past(init_val));

    assert_rate_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 3'd2 && !out) |-> count == CNT_W'(1));

    assert_square_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && mode_q == 3'd3 && !period_end) |=> count == $past(count) - CNT_W'(2));

    assert_gate_pause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !gate && !load && active &&
         (mode_q == 3'd0 || mode_q == 3'd2 || mode_q == 3'd3 || mode_q == 3'd4))
        |=> $stable(count));

    assert_periodic_retrig_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && active && !load && (mode_q == 3'd2 || mode_q == 3'd3)) |=> out);

    assert_irq_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_mask |-> !irq);
endmodule

bind pit_channel_core pit_chan_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .gate       (gate),
    .load       (load),
    .load_val   (load_val),
    .irq_mask   (irq_mask),
    .count      (count),
    .out        (out),
    .irq        (irq),
    .state      (state),
    .mode_q     (mode_q),
    .step       (step),
    .rise       (rise),
    .init_val   (init_val),
    .period_end (period_end)
);

// File: tb/test_pit_channel_core.sv
module test_pit_channel_core;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        gate = 1'b0;
    logic [2:0]  mode_sel = 3'd0;
    logic        load = 1'b0;
    logic [15:0] load_val = 16'd0;
    logic        irq_mask = 1'b0;
    logic [15:0] count;
    logic        out;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pit_channel_core i_pit_channel_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .gate(gate), .mode_sel(mode_sel),
        .load(load), .load_val(load_val), .irq_mask(irq_mask),
        .count(count), .out(out), .irq(irq)
    );

    task automatic chk(input string rq, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    function automatic string mode_tag(input int m);
        case (m)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            3: return "R6";
            4: return "R7";
            default: return "R8";
        endcase
    endfunction

    // expected count/out after k enabled ticks since a load of n in mode m
    task automatic expect_wave(input int m, input int n, input int k, output int c, output int o);
        int neff, p, h;
        neff = (n == 0) ? 65536 : n;
        case (m)
            2: begin
                p = k % neff;
                c = (p == 0) ? n : n - p;
                o = (c == 1) ? 0 : 1;
            end
            3: begin
                h = (n + 1) / 2;
                p = k % n;
                if (p < h) begin o = 1; c = n - 2 * p; end
                else       begin o = 0; c = (n & ~1) - 2 * (p - h); end
            end
            0, 1: begin
                c = (n - k) & 16'hFFFF;
                o = (k >= neff) ? 1 : 0;
            end
            default: begin
                c = (n - k) & 16'hFFFF;
                o = (k == neff) ? 0 : 1;
            end
        endcase
    endtask

    task automatic do_load(input int m, input int n, input logic g);
        @(negedge clk);
        load = 1'b1; mode_sel = 3'(m); load_val = 16'(n); gate = g;
        @(negedge clk);
        load = 1'b0;
        mode_sel = 3'(m) ^ 3'b011;   // later mode changes must be ignored (R2)
    endtask

    task automatic one_tick();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic sweep(input int m, input int n, input logic g, input int nt);
        int em, c, o;
        em = (m >= 6) ? m - 4 : m;
        do_load(m, n, g);
        chk("R2", "count after load", count, n);
        for (int k = 0; k <= nt; k++) begin
            if (k > 0) one_tick();
            expect_wave(em, n, k, c, o);
            chk(mode_tag(em), $sformatf("mode %0d n %0d k %0d count", m, n, k), count, c);
            chk(mode_tag(em), $sformatf("mode %0d n %0d k %0d out", m, n, k), out, o);
            chk("R11", "irq follows out", irq, o);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int saved;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "reset count", count, 0);
        chk("R1", "reset out", out, 1);
        chk("R1", "reset irq", irq, 1);
        gate = 1'b1;
        for (int i = 0; i < 4; i++) one_tick();
        chk("R1", "idle count", count, 0);
        chk("R1", "idle out", out, 1);

        // sweeps over modes and small values; modes 1 and 5 run with gate low
        for (int m = 0; m < 6; m++) begin
            for (int n = 1; n <= 9; n++) begin
                if ((m == 2 || m == 3) && n < 2) continue;
                sweep(m, n, (m == 1 || m == 5) ? 1'b0 : 1'b1, 2 * n + 3);
            end
        end
        // code aliasing (R2)
        sweep(6, 5, 1'b1, 12);
        sweep(7, 7, 1'b1, 16);

        // gate low pauses counting (R9)
        foreach (saved_modes[i]) begin
            do_load(saved_modes[i], 9, 1'b1);
            one_tick(); one_tick();
            saved = count;
            gate = 1'b0;
            for (int j = 0; j < 3; j++) one_tick();
            chk("R9", $sformatf("mode %0d paused count", saved_modes[i]), count, saved);
            gate = 1'b1;
            @(negedge clk);
        end

        // gate rising edge restarts (R4, R8, R10)
        for (int m = 1; m < 6; m++) begin
            if (m == 4) continue;
            do_load(m, 6, 1'b1);
            for (int j = 0; j < 3; j++) one_tick();
            gate = 1'b0;
            @(negedge clk);
            gate = 1'b1;
            @(negedge clk);
            chk((m == 1) ? "R4" : (m == 5) ? "R8" : "R10", $sformatf("mode %0d restart count", m), count, 6);
            chk((m == 1) ? "R4" : (m == 5) ? "R8" : "R10", $sformatf("mode %0d restart out", m), out, (m == 1) ? 0 : 1);
            if (m == 1) begin
                for (int j = 0; j < 6; j++) one_tick();
                chk("R4", "retriggered one-shot ends", out, 1);
            end
        end

        // load of zero gives 65536 ticks (R2, R3)
        do_load(0, 0, 1'b1);
        tick = 1'b1;
        repeat (65535) @(negedge clk);
        chk("R3", "zero load before end count", count, 1);
        chk("R3", "zero load before end out", out, 0);
        @(negedge clk);
        tick = 1'b0;
        chk("R2", "zero load end count", count, 0);
        chk("R2", "zero load end out", out, 1);

        // interrupt mask (R11)
        irq_mask = 1'b1;
        @(negedge clk);
        chk("R11", "masked irq", irq, 0);
        chk("R11", "out unaffected by mask", out, 1);
        irq_mask = 1'b0;
        @(negedge clk);
        chk("R11", "released irq", irq, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    int saved_modes[4] = '{0, 2, 3, 4};
endmodule